// File: doc/BRIEF.md
# Translation Table Base Address Former

This block keeps one 64-bit translation-table base register for a stage-1 address translator. Software-side logic loads the register through a write port and reads it back through a registered read port. The register is split into three fields: an address-space identifier in the top sixteen bits, base-address bits below them, and a flag in bit 0 that marks the tables as shared between processing elements.

From the stored value and a small set of configuration inputs, the block forms the 52-bit physical base address that a table walker starts from. The inputs are the table-alignment index x (3 to 48), a granule code, a physical-size select code and a flag that says whether 52-bit physical addresses exist. In wide (52-bit) mode the register's low nibble at bits 5:2 is moved up to address bits 51:48, and the alignment floor becomes the larger of x and 6. The block also raises two flags. One reports a set reserved bit. The other reports an address-size fault when wide addresses are requested on a part that cannot use them.

There is no state machine. The register is the only state, and every derived output follows it and the configuration inputs combinationally.

Top module: `tbl_base_former`

## Requirements
- R1: While reset is asserted and after it is released, the stored register is all zeros, so a read returns zero and every derived output is zero.
- R2: A write presented with `wr_en` is stored at that clock edge. A read requested with `rd_en` places the stored value on `rd_data` at that clock edge, and `rd_data` keeps it until the next read. Read-back equals the written value, apart from the case in R4.
- R3: `space_id` always equals register bits 63:48, and `shared_tbl` always equals register bit 0.
- R4: With `ID_WIDTH` = 8, register bits 63:56 are stored and read as zero, and `space_id[15:8]` is zero.
- R5: Wide mode is active only when `pa_sel` equals 3'b110 and `granule` equals 2'b10 (64KB). Granule codes are 2'b00 = 4KB, 2'b01 = 16KB, 2'b10 = 64KB and 2'b11 = treated as 4KB. With any other combination, including `pa_sel` = 3'b110 under a smaller granule, the block behaves as in R6.
- R6: Outside wide mode, `base_addr[47:x]` equals register bits 47:x, `base_addr[x-1:0]` is zero, and `base_addr[51:48]` is zero, whatever the reserved bits hold.
- R7: In wide mode, with z = x when x ≥ 6 and z = 6 otherwise, `base_addr[51:48]` equals register bits 5:2, `base_addr[47:z]` equals register bits 47:z, and `base_addr[z-1:0]` is zero.
- R8: Outside wide mode, `resv_set` is high exactly when any register bit in the range x-1 down to 1 is 1.
- R9: In wide mode, `resv_set` is high exactly when register bit 1 is 1, or when x > 6 and any register bit in the range x-1 down to 6 is 1.
- R10: `size_fault` is high exactly when `granule` is 64KB, `pa_sel` is 3'b110, `pa52_ok` is low and register bits 5:2 are nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Store `wr_data` at this edge |
| wr_data | input | 64 | Value to store |
| rd_en | input | 1 | Capture the register onto `rd_data` at this edge |
| rd_data | output | 64 | Registered read-back value |
| align_x | input | 6 | Table alignment index x, 3 to 48 |
| granule | input | 2 | Granule code (00 4KB, 01 16KB, 10 64KB, 11 as 4KB) |
| pa_sel | input | 3 | Physical-size select; 3'b110 requests 52-bit addresses |
| pa52_ok | input | 1 | 52-bit physical addresses are supported |
| space_id | output | 16 | Address-space identifier field |
| shared_tbl | output | 1 | Tables-shared flag (register bit 0) |
| base_addr | output | 52 | Formed table base address |
| resv_set | output | 1 | A reserved bit under the current mode is 1 |
| size_fault | output | 1 | Address-size fault |

## Verification
The hardest cases to reach from the ports are those where the alignment floor moves from x to 6 in wide mode. There, the same register bits 5:2 are dropped from the low address and reappear as address bits 51:48, while the reserved window shifts. To reach them, the bench loads a set of register patterns: all ones, alternating bits, a pattern with only bits 5:1 set, and pseudo-random words. For each pattern it sweeps every x from 3 to 48 against every granule code, four select codes and both support settings. Expected addresses and flags come from shift-and-mask arithmetic in the bench.

// File: rtl/tbf_pkg.sv
package tbf_pkg;
    localparam int REG_W      = 64;
    localparam int ADDR_W     = 52;
    localparam int LOW_W      = 48;
    localparam int ID_FIELD_W = 16;
    localparam int ID_LSB     = REG_W - ID_FIELD_W;
    localparam int WIDE_FLOOR = 6;
    localparam int NIB_LO     = 2;
    localparam int NIB_HI     = 5;
    localparam int X_W        = 6;

    typedef enum logic [1:0] {
        GRAN_4K   = 2'b00,
        GRAN_16K  = 2'b01,
        GRAN_64K  = 2'b10,
        GRAN_RSVD = 2'b11
    } gran_e;

    localparam logic [2:0] PA_SEL_WIDE = 3'b110;
endpackage

// File: rtl/tbf_store.sv
module tbf_store
    import tbf_pkg::*;
#(
    parameter int ID_WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             rd_en,
    output logic [REG_W-1:0] rd_data,
    output logic [REG_W-1:0] cur
);
    localparam int DROP_W = ID_FIELD_W - ID_WIDTH;
    localparam logic [REG_W-1:0] KEEP =
        ~(((REG_W'(1) << DROP_W) - REG_W'(1)) << (ID_LSB + ID_WIDTH));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur <= '0;
        end else if (wr_en) begin
            cur <= wr_data & KEEP;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= cur;
        end
    end

    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (cur == ($past(wr_data) & KEEP)));

    p_read_port_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> (rd_data == $past(cur)));

    generate
        if (ID_WIDTH < ID_FIELD_W) begin : g_narrow_id
            p_narrow_id_r4: assert property (@(posedge clk) disable iff (!rst_n)
                cur[REG_W-1 -: DROP_W] == '0);
        end
    endgenerate
endmodule

// File: rtl/tbf_mode.sv
module tbf_mode
    import tbf_pkg::*;
(
    input  logic [1:0] granule,
    input  logic [2:0] pa_sel,
    input  logic       pa52_ok,
    input  logic [3:0] hi_nib,
    output logic       wide_mode,
    output logic       size_fault
);
    gran_e gran;
    logic  wide_req;

    always_comb begin
        gran     = gran_e'(granule);
        wide_req = (pa_sel == PA_SEL_WIDE);
        unique case (gran)
            GRAN_64K: wide_mode = wide_req;
            GRAN_4K,
            GRAN_16K,
            GRAN_RSVD: wide_mode = 1'b0;
            default:   wide_mode = 1'b0;
        endcase
        size_fault = wide_mode && !pa52_ok && (hi_nib != 4'd0);
    end
endmodule

// File: rtl/tbf_assemble.sv
module tbf_assemble
    import tbf_pkg::*;
(
    input  logic [LOW_W-1:0]  cur_lo,
    input  logic [X_W-1:0]    align_x,
    input  logic              wide_mode,
    output logic [ADDR_W-1:0] base,
    output logic              resv_hit
);
    logic [X_W-1:0]   floor_x;
    logic [LOW_W-1:0] resv_bits;

    always_comb begin
        floor_x = (wide_mode && (align_x < X_W'(WIDE_FLOOR))) ? X_W'(WIDE_FLOOR) : align_x;
        for (int i = 0; i < LOW_W; i++) begin
            base[i] = (i >= int'(floor_x)) ? cur_lo[i] : 1'b0;
            if (wide_mode) begin
                resv_bits[i] = cur_lo[i] &&
                               ((i == 1) || ((i >= WIDE_FLOOR) && (i < int'(align_x))));
            end else begin
                resv_bits[i] = cur_lo[i] && (i >= 1) && (i < int'(align_x));
            end
        end
        base[ADDR_W-1:LOW_W] = wide_mode ? cur_lo[NIB_HI:NIB_LO] : 4'd0;
        resv_hit = |resv_bits;
    end
endmodule

// File: rtl/tbl_base_former.sv
module tbl_base_former
    import tbf_pkg::*;
#(
    parameter int ID_WIDTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [63:0]       wr_data,
    input  logic              rd_en,
    output logic [63:0]       rd_data,
    input  logic [5:0]        align_x,
    input  logic [1:0]        granule,
    input  logic [2:0]        pa_sel,
    input  logic              pa52_ok,
    output logic [15:0]       space_id,
    output logic              shared_tbl,
    output logic [51:0]       base_addr,
    output logic              resv_set,
    output logic              size_fault
);
    logic [REG_W-1:0] cur;
    logic             wide_mode;

    tbf_store #(.ID_WIDTH(ID_WIDTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_data (rd_data),
        .cur     (cur)
    );

    tbf_mode u_mode (
        .granule    (granule),
        .pa_sel     (pa_sel),
        .pa52_ok    (pa52_ok),
        .hi_nib     (cur[NIB_HI:NIB_LO]),
        .wide_mode  (wide_mode),
        .size_fault (size_fault)
    );

    tbf_assemble u_asm (
        .cur_lo    (cur[LOW_W-1:0]),
        .align_x   (align_x),
        .wide_mode (wide_mode),
        .base      (base_addr),
        .resv_hit  (resv_set)
    );

    assign space_id   = cur[REG_W-1:ID_LSB];
    assign shared_tbl = cur[0];

    p_wide_upper_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wide_mode |-> (base_addr[ADDR_W-1:LOW_W] == cur[NIB_HI:NIB_LO]));

    p_narrow_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pa_sel != PA_SEL_WIDE) |-> (base_addr[ADDR_W-1:LOW_W] == 4'd0));

    p_below_x_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (align_x <= 6'd48) |->
            ((base_addr[LOW_W-1:0] & ((LOW_W'(1) << align_x) - LOW_W'(1))) == '0));

    p_fault_needs_wide_r10: assert property (@(posedge clk) disable iff (!rst_n)
        size_fault |-> (wide_mode && !pa52_ok && (granule == 2'b10)));

    p_wide_bit1_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wide_mode && cur[1]) |-> resv_set);
endmodule

// File: tb/tbl_base_former_tb.sv
module tbl_base_former_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [63:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [5:0]  align_x = 6'd12;
    logic [1:0]  granule = 2'b00;
    logic [2:0]  pa_sel = 3'b000;
    logic        pa52_ok = 1'b0;

    logic [63:0] rd_data, rd_data_n;
    logic [15:0] space_id, space_id_n;
    logic        shared_tbl, shared_tbl_n;
    logic [51:0] base_addr, base_addr_n;
    logic        resv_set, resv_set_n;
    logic        size_fault, size_fault_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    tbl_base_former u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .align_x(align_x),
        .granule(granule), .pa_sel(pa_sel), .pa52_ok(pa52_ok),
        .space_id(space_id), .shared_tbl(shared_tbl), .base_addr(base_addr),
        .resv_set(resv_set), .size_fault(size_fault)
    );

    tbl_base_former #(.ID_WIDTH(8)) u_dut_narrow (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data_n), .align_x(align_x),
        .granule(granule), .pa_sel(pa_sel), .pa52_ok(pa52_ok),
        .space_id(space_id_n), .shared_tbl(shared_tbl_n), .base_addr(base_addr_n),
        .resv_set(resv_set_n), .size_fault(size_fault_n)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic write_reg(input logic [63:0] v);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic sweep(input logic [63:0] r);
        for (int x = 3; x <= 48; x++) begin
            for (int g = 0; g < 4; g++) begin
                for (int k = 0; k < 4; k++) begin
                    for (int ok = 0; ok < 2; ok++) begin
                        logic        wide;
                        int          z;
                        logic [63:0] eb, msk, lowm;
                        logic        er, ef;
                        align_x = 6'(x);
                        granule = 2'(g);
                        pa_sel  = (k == 0) ? 3'd0 : 3'(k + 4);
                        pa52_ok = 1'(ok);
                        #1;
                        wide = (pa_sel == 3'b110) && (g == 2);
                        z    = (wide && x < 6) ? 6 : x;
                        eb   = ((r & 64'hFFFF_FFFF_FFFF) >> z) << z;
                        if (wide) eb[51:48] = r[5:2];
                        lowm = (64'd1 << x) - 64'd1;
                        msk  = wide ? (64'd2 | ((x > 6) ? (lowm & ~64'h3F) : 64'd0))
                                    : (lowm & ~64'd1);
                        er   = |(r & msk);
                        ef   = (g == 2) && (pa_sel == 3'b110) && !ok && (r[5:2] != 0);
                        check(base_addr == eb[51:0],
                              wide ? "R7 wide base" : ((pa_sel == 3'b110) ? "R5 mode gate" : "R6 narrow base"),
                              64'(base_addr), eb);
                        check(resv_set == er, wide ? "R9 wide reserved" : "R8 narrow reserved",
                              64'(resv_set), 64'(er));
                        check(size_fault == ef, "R10 size fault", 64'(size_fault), 64'(ef));
                    end
                end
            end
        end
    endtask

    initial begin
        logic [63:0] pats [6];
        pats[0] = 64'hFFFF_FFFF_FFFF_FFFF;
        pats[1] = 64'hA5A5_5A5A_C3C3_3C3C;
        pats[2] = 64'h1234_0000_0000_003E;
        pats[3] = 64'h0000_8000_0000_0001;
        pats[4] = {$urandom, $urandom};
        pats[5] = {$urandom, $urandom};

        repeat (3) @(negedge clk);
        check(rd_data == 0 && base_addr == 0, "R1 in reset", rd_data, 0);
        rst_n = 1'b1;
        @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check(rd_data == 0, "R1 read after reset", rd_data, 0);
        check(space_id == 0 && !shared_tbl && !resv_set && !size_fault,
              "R1 fields after reset", 64'(space_id), 0);

        for (int p = 0; p < 6; p++) begin
            logic [63:0] r;
            r = pats[p];
            write_reg(r);
            check(rd_data == r, "R2 read-back", rd_data, r);
            check(space_id == r[63:48], "R3 identifier", 64'(space_id), 64'(r[63:48]));
            check(shared_tbl == r[0], "R3 shared flag", 64'(shared_tbl), 64'(r[0]));
            check(rd_data_n == {8'h00, r[55:0]}, "R4 narrow read-back", rd_data_n,
                  {8'h00, r[55:0]});
            check(space_id_n == {8'h00, r[55:48]}, "R4 narrow identifier",
                  64'(space_id_n), 64'({8'h00, r[55:48]}));
            @(negedge clk);
            check(rd_data == r, "R2 read data held", rd_data, r);
            sweep(r);
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule